// File: doc/BRIEF.md
# Mailbox Bridge with Countdown Timer

This block sits between a host processor and a coprocessor and is reached by the coprocessor through a byte-wide register port. It has two single-byte mailboxes. The outgoing mailbox carries bytes from the coprocessor to the host, and the incoming mailbox carries bytes from the host to the coprocessor. Each mailbox has a ready flag. The host side uses a plain push port on the incoming mailbox and a pop port on the outgoing mailbox, with no address decoding on that side.

The block also holds a countdown timer whose width is a whole number of bytes. The coprocessor fills a staging latch one byte at a time. Writing the most significant byte moves the whole image into the counter in the same access. On each load the busy flag records whether the loaded value was zero. A status byte at a shared offset reports both ready flags and busy. Reading the incoming mailbox consumes it, so the coprocessor needs one access to collect a message.

Top module: `mbx_timer_bridge`

## Requirements
- R1: A coprocessor write at offset 0x00 stores the byte in the outgoing mailbox. From the next cycle, `host_rdata` shows that byte and `out_ready` is 1.
- R2: A coprocessor read at offset 0x10 while `in_ready` is 1 returns the incoming byte in the same cycle and clears `in_ready` at the clock edge.
- R3: A coprocessor read at offset 0x10 while `in_ready` is 0 returns 0x00 and changes no state.
- R4: A read at offset 0x20 returns the status byte. Bit 0 is `out_ready`, bit 3 is `in_ready`, bit 7 is `busy`, and all other bits are 0.
- R5: Writes at offsets 0x20, 0x24 and 0x28 replace latch bits [7:0], [15:8] and [23:16] respectively and leave the other latch bits unchanged. Writes at 0x20 and 0x24 do not change the counter.
- R6: A write at offset 0x28 loads the counter with {written byte, latch[15:0]}. The new value appears on `tmr_count` in the next cycle.
- R7: On each load, `busy` becomes 1 if the loaded value is zero and 0 otherwise. Between loads `busy` keeps its value.
- R8: While `tick` is 1, the counter decrements by one if it is nonzero and holds at zero otherwise. A load in the same cycle takes priority over the tick.
- R9: `host_push` stores `host_wdata` in the incoming mailbox and sets `in_ready`. If a coprocessor read of offset 0x10 happens in the same cycle, the push wins: the read returns the old byte, and `in_ready` stays 1 with the new byte.
- R10: `host_pop` clears `out_ready`. If a coprocessor write at offset 0x00 happens in the same cycle, the write wins and `out_ready` stays 1 with the new byte.
- R11: Reset clears both mailbox bytes, both ready flags, the latch, the counter and `busy`.
- R12: A write at any other offset has no effect, including a write at 0x10. A read at any offset other than 0x10 and 0x20 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_addr | input | ADDR_W | Coprocessor register offset |
| cp_wdata | input | 8 | Coprocessor write byte |
| cp_wr | input | 1 | Coprocessor write strobe |
| cp_rd | input | 1 | Coprocessor read strobe |
| cp_rdata | output | 8 | Read byte, valid in the cycle of the strobe |
| host_push | input | 1 | Host deposits a byte in the incoming mailbox |
| host_wdata | input | 8 | Byte deposited by the host |
| host_pop | input | 1 | Host consumes the outgoing mailbox |
| host_rdata | output | 8 | Outgoing mailbox byte |
| out_ready | output | 1 | Outgoing mailbox holds an unread byte |
| in_ready | output | 1 | Incoming mailbox holds an unread byte |
| tick | input | 1 | Timer decrement enable |
| busy | output | 1 | Set when the last load was zero |
| tmr_count | output | 8*NBYTES | Current counter value |

## Verification
The bench builds the block with its default parameters: a 6-bit offset space and a three-byte timer. With these values every decoded offset is reachable, including 0x28, where the last latch byte both stores and loads. Because the latch is split into three bytes, the bench can check that each byte keeps its value through partial rewrites of the others. The bench loads small counts so that rundown to zero and holding at zero both fit in a few ticks. It uses full 24-bit loads to confirm byte placement. It also drives the same-cycle collisions directly: push against consume, write against pop, and load against tick.

// File: rtl/mbxb_pkg.sv
package mbxb_pkg;

  // Register offsets. The latch byte order is behaviour: the last one loads.
  localparam int unsigned OFS_TX     = 'h00;
  localparam int unsigned OFS_RX     = 'h10;
  localparam int unsigned OFS_STAT   = 'h20;
  localparam int unsigned OFS_LAT    = 'h20;
  localparam int unsigned LAT_STRIDE = 4;

  localparam int unsigned ST_OUT_BIT  = 0;
  localparam int unsigned ST_IN_BIT   = 3;
  localparam int unsigned ST_BUSY_BIT = 7;

  function automatic logic [7:0] stat_pack(input logic out_rdy, input logic in_rdy,
                                           input logic bsy);
    logic [7:0] s;
    s = '0;
    s[ST_OUT_BIT]  = out_rdy;
    s[ST_IN_BIT]   = in_rdy;
    s[ST_BUSY_BIT] = bsy;
    return s;
  endfunction

endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          put,
  input  logic [DW-1:0] put_data,
  input  logic          take,
  output logic [DW-1:0] data,
  output logic          full
);

  // A put outranks a take in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
    end else if (put) begin
      data <= put_data;
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/cdown_timer.sv
module cdown_timer #(
  parameter  int NBYTES = 3,
  localparam int TMR_W  = 8 * NBYTES,
  localparam int SELW   = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lat_we,
  input  logic [SELW-1:0] lat_sel,
  input  logic [7:0]      lat_byte,
  input  logic            tick,
  output logic [TMR_W-1:0] count,
  output logic            busy,
  output logic            load_evt
);

  localparam logic [SELW-1:0] TOP_SEL = SELW'(NBYTES - 1);

  logic [7:0]       lat_q [NBYTES];
  logic [TMR_W-1:0] lat_img;

  function automatic logic [TMR_W-1:0] tmr_step(input logic [TMR_W-1:0] cur,
                                                input logic en);
    return (en && (cur != '0)) ? cur - TMR_W'(1) : cur;
  endfunction

  assign load_evt = lat_we && (lat_sel == TOP_SEL);

  for (genvar g = 0; g < NBYTES; g++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lat_q[g] <= '0;
      else if (lat_we && (lat_sel == SELW'(g)))
        lat_q[g] <= lat_byte;
    end
  end

  // The image seen by a load uses the byte being written for the top slot.
  always_comb begin
    for (int i = 0; i < NBYTES; i++)
      lat_img[8*i +: 8] = (i == NBYTES - 1) ? lat_byte : lat_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      busy  <= 1'b0;
    end else if (load_evt) begin
      count <= lat_img;
      busy  <= (lat_img == '0);
    end else begin
      count <= tmr_step(count, tick);
    end
  end

endmodule

// File: rtl/mbx_timer_bridge.sv
module mbx_timer_bridge
  import mbxb_pkg::*;
#(
  parameter  int ADDR_W = 6,
  parameter  int NBYTES = 3,
  localparam int TMR_W  = 8 * NBYTES,
  localparam int SELW   = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cp_addr,
  input  logic [7:0]        cp_wdata,
  input  logic              cp_wr,
  input  logic              cp_rd,
  output logic [7:0]        cp_rdata,
  input  logic              host_push,
  input  logic [7:0]        host_wdata,
  input  logic              host_pop,
  output logic [7:0]        host_rdata,
  output logic              out_ready,
  output logic              in_ready,
  input  logic              tick,
  output logic              busy,
  output logic [TMR_W-1:0]  tmr_count
);

  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(OFS_TX);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(OFS_RX);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic              tx_put;
  logic              rx_take;
  logic              rx_sel;
  logic [7:0]        rx_data;
  logic [NBYTES-1:0] lat_hit;
  logic              lat_we;
  logic [SELW-1:0]   lat_sel;
  logic              tmr_load;

  assign tx_put  = cp_wr && (cp_addr == A_TX);
  assign rx_sel  = cp_rd && (cp_addr == A_RX);
  assign rx_take = rx_sel && in_ready;

  for (genvar g = 0; g < NBYTES; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] A_LAT = ADDR_W'(OFS_LAT + g * LAT_STRIDE);
    assign lat_hit[g] = cp_wr && (cp_addr == A_LAT);
  end

  assign lat_we = |lat_hit;

  always_comb begin
    lat_sel = '0;
    for (int i = 0; i < NBYTES; i++)
      if (lat_hit[i]) lat_sel = SELW'(i);
  end

  mbx_slot #(.DW(8)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .put      (tx_put),
    .put_data (cp_wdata),
    .take     (host_pop),
    .data     (host_rdata),
    .full     (out_ready)
  );

  mbx_slot #(.DW(8)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .put      (host_push),
    .put_data (host_wdata),
    .take     (rx_take),
    .data     (rx_data),
    .full     (in_ready)
  );

  cdown_timer #(.NBYTES(NBYTES)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .lat_we   (lat_we),
    .lat_sel  (lat_sel),
    .lat_byte (cp_wdata),
    .tick     (tick),
    .count    (tmr_count),
    .busy     (busy),
    .load_evt (tmr_load)
  );

  always_comb begin
    cp_rdata = 8'h00;
    if (cp_rd) begin
      if (cp_addr == A_RX)
        cp_rdata = in_ready ? rx_data : 8'h00;
      else if (cp_addr == A_STAT)
        cp_rdata = stat_pack(out_ready, in_ready, busy);
    end
  end

endmodule

// File: rtl/mbxb_checker.sv
module mbxb_checker #(
  parameter  int ADDR_W = 6,
  parameter  int NBYTES = 3,
  localparam int TMR_W  = 8 * NBYTES
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cp_addr,
  input logic [7:0]        cp_wdata,
  input logic              cp_wr,
  input logic              cp_rd,
  input logic [7:0]        cp_rdata,
  input logic              host_push,
  input logic              host_pop,
  input logic [7:0]        host_rdata,
  input logic              out_ready,
  input logic              in_ready,
  input logic              tick,
  input logic              busy,
  input logic [TMR_W-1:0]  tmr_count,
  input logic              tmr_load
);

  localparam logic [ADDR_W-1:0] C_TX   = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] C_RX   = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] C_STAT = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] C_TOP  = ADDR_W'('h20 + 4 * (NBYTES - 1));

  AST_TX_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_wr && cp_addr == C_TX) |=> (out_ready && host_rdata == $past(cp_wdata))); // R1

  AST_RX_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_rd && cp_addr == C_RX && !host_push) |=> !in_ready); // R2

  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_rd && cp_addr == C_RX && !in_ready) |-> (cp_rdata == 8'h00)); // R3

  AST_STATUS_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_rd && cp_addr == C_STAT) |->
      (cp_rdata == {busy, 3'b000, in_ready, 2'b00, out_ready})); // R4

  AST_TOP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_wr && cp_addr == C_TOP) |-> tmr_load); // R6

  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_load |=> (busy == (tmr_count == '0))); // R7

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_load |=> $stable(busy)); // R7

  AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tmr_count != '0 && !tmr_load) |=> (tmr_count == $past(tmr_count) - TMR_W'(1))); // R8

  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_count == '0 && !tmr_load) |=> (tmr_count == '0)); // R8

  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    host_push |=> in_ready); // R9

  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop && !(cp_wr && cp_addr == C_TX)) |=> !out_ready); // R10

endmodule

bind mbx_timer_bridge mbxb_checker #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cp_addr    (cp_addr),
  .cp_wdata   (cp_wdata),
  .cp_wr      (cp_wr),
  .cp_rd      (cp_rd),
  .cp_rdata   (cp_rdata),
  .host_push  (host_push),
  .host_pop   (host_pop),
  .host_rdata (host_rdata),
  .out_ready  (out_ready),
  .in_ready   (in_ready),
  .tick       (tick),
  .busy       (busy),
  .tmr_count  (tmr_count),
  .tmr_load   (tmr_load)
);

// File: tb/sim_mbx_timer_bridge.sv
`timescale 1ns/1ps
module sim_mbx_timer_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cp_addr = '0;
  logic [7:0]  cp_wdata = '0;
  logic        cp_wr = 1'b0, cp_rd = 1'b0;
  logic [7:0]  cp_rdata;
  logic        host_push = 1'b0, host_pop = 1'b0, tick = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        out_ready, in_ready, busy;
  logic [23:0] tmr_count;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  cap_rd, cap_hr;
  logic [23:0] cap_cnt;
  logic        cap_out, cap_in, cap_busy;

  always #4 clk = ~clk;  // 125 MHz

  mbx_timer_bridge u0 (
    .clk(clk), .rst_n(rst_n), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
    .cp_wr(cp_wr), .cp_rd(cp_rd), .cp_rdata(cp_rdata),
    .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
    .host_rdata(host_rdata), .out_ready(out_ready), .in_ready(in_ready),
    .tick(tick), .busy(busy), .tmr_count(tmr_count)
  );

  // ops: 0 write, 1 read+check, 2 push, 3 pop+check host byte, 4 tick, 5 check count[7:0]
  // row: {op[2:0], addr[7:0], data[7:0], exp[7:0], req[3:0]}
  localparam int NV = 35;
  localparam logic [30:0] VEC [NV] = '{
    {3'd1, 8'h20, 8'h00, 8'h00, 4'd11}, // R11 status clear after reset
    {3'd1, 8'h10, 8'h00, 8'h00, 4'd3},  // R3 empty incoming reads zero
    {3'd0, 8'h00, 8'hA5, 8'h00, 4'd0},  // R1 write outgoing
    {3'd1, 8'h20, 8'h00, 8'h01, 4'd4},  // R4 bit0 out ready
    {3'd3, 8'h00, 8'h00, 8'hA5, 4'd1},  // R1 host sees byte, then pops
    {3'd1, 8'h20, 8'h00, 8'h00, 4'd10}, // R10 pop cleared
    {3'd2, 8'h00, 8'h3C, 8'h00, 4'd0},  // R9 push
    {3'd1, 8'h20, 8'h00, 8'h08, 4'd9},  // R9 bit3 in ready
    {3'd1, 8'h10, 8'h00, 8'h3C, 4'd2},  // R2 consume
    {3'd1, 8'h10, 8'h00, 8'h00, 4'd2},  // R2 now empty
    {3'd1, 8'h20, 8'h00, 8'h00, 4'd2},  // R2 flag cleared
    {3'd0, 8'h10, 8'h77, 8'h00, 4'd0},  // R12 write to read-only offset
    {3'd1, 8'h20, 8'h00, 8'h00, 4'd12}, // R12 no flag change
    {3'd1, 8'h04, 8'h00, 8'h00, 4'd12}, // R12 unmapped read
    {3'd1, 8'h10, 8'h00, 8'h00, 4'd12}, // R12 incoming still empty
    {3'd0, 8'h20, 8'h03, 8'h00, 4'd0},  // latch byte 0
    {3'd0, 8'h24, 8'h00, 8'h00, 4'd0},  // latch byte 1
    {3'd0, 8'h28, 8'h00, 8'h00, 4'd0},  // latch byte 2 + load
    {3'd5, 8'h00, 8'h00, 8'h03, 4'd6},  // R6 loaded 3
    {3'd4, 8'h00, 8'h00, 8'h00, 4'd0},
    {3'd5, 8'h00, 8'h00, 8'h02, 4'd8},  // R8 decrement
    {3'd4, 8'h00, 8'h00, 8'h00, 4'd0},
    {3'd4, 8'h00, 8'h00, 8'h00, 4'd0},
    {3'd5, 8'h00, 8'h00, 8'h00, 4'd8},  // R8 reached zero
    {3'd4, 8'h00, 8'h00, 8'h00, 4'd0},
    {3'd5, 8'h00, 8'h00, 8'h00, 4'd8},  // R8 holds at zero
    {3'd0, 8'h20, 8'h00, 8'h00, 4'd0},
    {3'd0, 8'h28, 8'h00, 8'h00, 4'd0},  // zero load
    {3'd1, 8'h20, 8'h00, 8'h80, 4'd7},  // R7 busy on zero load
    {3'd0, 8'h24, 8'h01, 8'h00, 4'd0},
    {3'd5, 8'h00, 8'h00, 8'h00, 4'd5},  // R5 middle byte does not load
    {3'd1, 8'h20, 8'h00, 8'h80, 4'd7},  // R7 busy held
    {3'd0, 8'h28, 8'h00, 8'h00, 4'd0},  // load 0x000100
    {3'd1, 8'h20, 8'h00, 8'h00, 4'd7},  // R7 nonzero load clears busy
    {3'd5, 8'h00, 8'h00, 8'h00, 4'd6}   // R6 low byte of 0x000100
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic [7:0] a,
                     input logic [7:0] d, input logic push, input logic [7:0] pd,
                     input logic pop, input logic tk);
    @(negedge clk);
    cp_wr = wr; cp_rd = rd; cp_addr = a[5:0]; cp_wdata = d;
    host_push = push; host_wdata = pd; host_pop = pop; tick = tk;
    #1;
    cap_rd = cp_rdata; cap_hr = host_rdata; cap_cnt = tmr_count;
    cap_out = out_ready; cap_in = in_ready; cap_busy = busy;
  endtask

  task automatic idle();
    cyc(0, 0, 8'h00, 8'h00, 0, 8'h00, 0, 0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [7:0] a, d, e;
      string rq;
      op = VEC[i][30:28]; a = VEC[i][27:20]; d = VEC[i][19:12]; e = VEC[i][11:4];
      rq = $sformatf("R%0d row %0d", VEC[i][3:0], i);
      case (op)
        3'd0: cyc(1, 0, a, d, 0, 8'h00, 0, 0);
        3'd1: begin cyc(0, 1, a, 8'h00, 0, 8'h00, 0, 0); chk(rq, 32'(cap_rd), 32'(e)); end
        3'd2: cyc(0, 0, 8'h00, 8'h00, 1, d, 0, 0);
        3'd3: begin cyc(0, 0, 8'h00, 8'h00, 0, 8'h00, 1, 0); chk(rq, 32'(cap_hr), 32'(e)); end
        3'd4: cyc(0, 0, 8'h00, 8'h00, 0, 8'h00, 0, 1);
        default: begin idle(); chk(rq, 32'(cap_cnt[7:0]), 32'(e)); end
      endcase
    end

    // R6: full three-byte placement
    cyc(1, 0, 8'h20, 8'h12, 0, 8'h00, 0, 0);
    cyc(1, 0, 8'h24, 8'h34, 0, 8'h00, 0, 0);
    cyc(1, 0, 8'h28, 8'h56, 0, 8'h00, 0, 0);
    idle();
    chk("R6 full load", 32'(cap_cnt), 32'h563412);
    chk("R7 nonzero load busy", 32'(cap_busy), 32'h0);

    // R5: low byte rewrite keeps others, counter untouched until top write
    cyc(1, 0, 8'h20, 8'hFF, 0, 8'h00, 0, 0);
    idle();
    chk("R5 no load on low byte", 32'(cap_cnt), 32'h563412);
    cyc(1, 0, 8'h28, 8'h56, 0, 8'h00, 0, 0);
    idle();
    chk("R5 byte1 retained", 32'(cap_cnt), 32'h5634FF);

    // R8: load beats tick, then tick decrements
    cyc(1, 0, 8'h28, 8'h00, 0, 8'h00, 0, 1);
    idle();
    chk("R8 load over tick", 32'(cap_cnt), 32'h0034FF);
    cyc(0, 0, 8'h00, 8'h00, 0, 8'h00, 0, 1);
    idle();
    chk("R8 decrement", 32'(cap_cnt), 32'h0034FE);

    // R9: push collides with a consuming read
    cyc(0, 0, 8'h00, 8'h00, 1, 8'h11, 0, 0);
    cyc(0, 1, 8'h10, 8'h00, 1, 8'h22, 0, 0);
    chk("R9 read returns old byte", 32'(cap_rd), 32'h11);
    idle();
    chk("R9 ready kept", 32'(cap_in), 32'h1);
    cyc(0, 1, 8'h10, 8'h00, 0, 8'h00, 0, 0);
    chk("R9 new byte", 32'(cap_rd), 32'h22);
    idle();
    chk("R2 flag clear", 32'(cap_in), 32'h0);

    // R10: write collides with pop
    cyc(1, 0, 8'h00, 8'h44, 0, 8'h00, 1, 0);
    idle();
    chk("R10 write wins ready", 32'(cap_out), 32'h1);
    chk("R1 new outgoing byte", 32'(cap_hr), 32'h44);

    // R11: reset mid-operation
    cyc(0, 0, 8'h00, 8'h00, 1, 8'h99, 0, 0);
    @(negedge clk);
    host_push = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R11 out_ready", 32'(out_ready), 32'h0);
    chk("R11 in_ready", 32'(in_ready), 32'h0);
    chk("R11 host_rdata", 32'(host_rdata), 32'h0);
    chk("R11 count", 32'(tmr_count), 32'h0);
    chk("R11 busy", 32'(busy), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 0, 8'h28, 8'h00, 0, 8'h00, 0, 0);
    idle();
    chk("R11 latch cleared", 32'(cap_cnt), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule